// File: doc/BRIEF.md
# Vectored Trap and Return Controller

This block decides, one instruction at a time, whether the core must leave its normal flow. It takes the trap or return state from the pipeline and works out every state change that results. On an instruction boundary it looks at the global interrupt enable and at the per-source enable and pending masks. In any cycle it may also receive a synchronous exception strobe with a 4-bit code and the faulting PC, or a return-from-trap strobe. The block holds no CSRs itself. It reads the current status bits and the saved return address as inputs, and it produces registered update values with write strobes that the CSR file applies.

The decision is registered once, so every result appears on the outputs in the cycle after the stimulus and stays there for exactly one cycle. A trap produces a redirect, the values for the return address, cause and status registers, and a trap-taken pulse. A return produces a redirect to the saved address and a status update only. Exceptions go to a fixed handler base. Interrupts go to that base plus four times the cause code.

Top module: `vec_trap_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: An interrupt is taken only when the boundary strobe is high, the global enable is high, and at least one of bits 3 (software), 7 (timer) or 11 (external) is set in both the enable mask and the pending mask; all other mask bits are ignored.
- R3: When several sources are enabled and pending together, the external source (11) wins, then software (3), then timer (7).
- R4: An interrupt redirects to 0x0000_0008 + 4*cause (0x14, 0x24 or 0x34), and the cause value has bit 31 set with the code in bits 3:0.
- R5: An exception redirects to 0x0000_0008, and the cause value holds the code with bit 31 clear, for codes 0, 1, 2, 3, 5, 7 and 11.
- R6: An exception strobe whose code is 4, 6, 8, 9, 10 or 12 to 15 is reported with code 2.
- R7: On every trap the return-address output equals the PC presented with the stimulus.
- R8: On trap entry the new previous-enable bit equals the old global enable, and the new global enable is 0.
- R9: A return strobe redirects to the saved return address, sets the new global enable to the old previous-enable bit, and sets the new previous-enable bit to 1, without a trap pulse or a cause write.
- R10: A taken interrupt has priority over an exception and a return in the same cycle, and an exception has priority over a return.
- R11: All results appear in the cycle after the stimulus and last for exactly one cycle.
- R12: A cycle with no taken interrupt, no exception and no return, which includes a no-op wait instruction, produces no redirect, no trap pulse and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary: interrupts are sampled this cycle |
| glb_ie_i | input | 1 | Current global interrupt enable |
| prev_ie_i | input | 1 | Current previous-enable bit |
| irq_en_i | input | 32 | Per-source interrupt enable mask |
| irq_pend_i | input | 32 | Per-source interrupt pending mask |
| exc_vld_i | input | 1 | Synchronous exception strobe |
| exc_code_i | input | 4 | Exception code |
| pc_i | input | 32 | PC of the current instruction |
| ret_i | input | 1 | Return-from-trap strobe |
| saved_pc_i | input | 32 | Current saved return address |
| redir_vld_o | output | 1 | Redirect the fetch this cycle |
| redir_pc_o | output | 32 | Redirect target |
| trap_o | output | 1 | Trap-taken pulse |
| cause_we_o | output | 1 | Write return address and cause |
| epc_o | output | 32 | New return address |
| cause_o | output | 32 | New cause value |
| stat_we_o | output | 1 | Write the status enable bits |
| glb_ie_o | output | 1 | New global enable |
| prev_ie_o | output | 1 | New previous-enable bit |

## Verification
The bench drives cycles where an interrupt, an exception and a return are all presented together. A design with the priority inverted would take the exception or the return and save the wrong cause. Masks are set so that the only set bits are outside positions 3, 7 and 11, or so that one source is enabled but not pending. A design that reduced the whole mask would trap where it should not. Unsupported exception codes and cycles without a boundary strobe are swept as well. The bench also checks that the enable-bit swap runs in opposite directions on entry and on return, because a design that reused the entry swap for the return would leave interrupts disabled after the handler.

// File: rtl/trap_pkg.sv
package trap_pkg;
    parameter int XLEN = 32;
    parameter int CODE_W = 4;
    parameter logic [XLEN-1:0] TVEC_BASE = 32'h0000_0008;
    parameter int N_SRC = 3;
    // interrupt sources listed from highest to lowest priority
    parameter int SRC_BIT [N_SRC] = '{11, 3, 7};
    parameter logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;

    typedef struct packed {
        logic            redir_vld;
        logic [XLEN-1:0] redir_pc;
        logic            trap;
        logic            cause_we;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic            stat_we;
        logic            glb_ie;
        logic            prev_ie;
    } trap_out_t;

    function automatic logic [CODE_W-1:0] legal_code(input logic [CODE_W-1:0] c);
        case (c)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd11: legal_code = c;
            default:                                   legal_code = CODE_ILLEGAL;
        endcase
    endfunction
endpackage

// File: rtl/irq_prio.sv
module irq_prio
    import trap_pkg::*;
(
    input  logic              boundary_i,
    input  logic              glb_ie_i,
    input  logic [XLEN-1:0]   en_i,
    input  logic [XLEN-1:0]   pend_i,
    output logic              req_o,
    output logic [CODE_W-1:0] cause_o,
    output logic [N_SRC-1:0]  grant_o
);
    logic [N_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_hit
            assign hit[g] = en_i[SRC_BIT[g]] & pend_i[SRC_BIT[g]];
        end
    endgenerate

    always_comb begin
        grant_o = '0;
        cause_o = '0;
        // walk lowest priority first so the highest one overrides
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                cause_o = CODE_W'(SRC_BIT[i]);
            end
        end
        if (!(boundary_i && glb_ie_i)) begin
            grant_o = '0;
            cause_o = '0;
        end
        req_o = |grant_o;
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req_i,
    input  logic [CODE_W-1:0] irq_cause_i,
    input  logic [N_SRC-1:0]  irq_grant_i,
    input  logic              glb_ie_i,
    input  logic              prev_ie_i,
    input  logic              exc_vld_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              ret_i,
    input  logic [XLEN-1:0]   saved_pc_i,
    output trap_out_t         out_o
);
    trap_out_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (irq_req_i) begin
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = TVEC_BASE + (XLEN'(irq_cause_i) << 2);
            st_d.trap      = 1'b1;
            st_d.cause_we  = 1'b1;
            st_d.epc       = pc_i;
            st_d.cause     = {1'b1, {(XLEN-1-CODE_W){1'b0}}, irq_cause_i};
            st_d.stat_we   = 1'b1;
            st_d.glb_ie    = 1'b0;
            st_d.prev_ie   = glb_ie_i;
        end else if (exc_vld_i) begin
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = TVEC_BASE;
            st_d.trap      = 1'b1;
            st_d.cause_we  = 1'b1;
            st_d.epc       = pc_i;
            st_d.cause     = XLEN'(legal_code(exc_code_i));
            st_d.stat_we   = 1'b1;
            st_d.glb_ie    = 1'b0;
            st_d.prev_ie   = glb_ie_i;
        end else if (ret_i) begin
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = saved_pc_i;
            st_d.stat_we   = 1'b1;
            st_d.glb_ie    = prev_ie_i;
            st_d.prev_ie   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q;

    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_grant_i));
    a_r8_entry_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trap |-> (!st_q.glb_ie && st_q.cause_we && st_q.redir_vld));
    a_r7_epc_is_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_vld_i || irq_req_i) |=> (st_q.trap && st_q.epc == $past(pc_i)));
    a_r5_exc_base: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trap && !st_q.cause[XLEN-1]) |-> st_q.redir_pc == TVEC_BASE);
    a_r9_ret_sets_prev: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat_we && !st_q.trap) |-> (st_q.prev_ie && !st_q.cause_we));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req_i && !exc_vld_i && !ret_i) |=> (!st_q.redir_vld && !st_q.stat_we));
endmodule

// File: rtl/vec_trap_ctrl.sv
module vec_trap_ctrl
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              glb_ie_i,
    input  logic              prev_ie_i,
    input  logic [XLEN-1:0]   irq_en_i,
    input  logic [XLEN-1:0]   irq_pend_i,
    input  logic              exc_vld_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              ret_i,
    input  logic [XLEN-1:0]   saved_pc_i,
    output logic              redir_vld_o,
    output logic [XLEN-1:0]   redir_pc_o,
    output logic              trap_o,
    output logic              cause_we_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic              stat_we_o,
    output logic              glb_ie_o,
    output logic              prev_ie_o
);
    logic              irq_req;
    logic [CODE_W-1:0] irq_cause;
    logic [N_SRC-1:0]  irq_grant;
    trap_out_t         res;

    irq_prio u_prio (
        .boundary_i (boundary_i),
        .glb_ie_i   (glb_ie_i),
        .en_i       (irq_en_i),
        .pend_i     (irq_pend_i),
        .req_o      (irq_req),
        .cause_o    (irq_cause),
        .grant_o    (irq_grant)
    );

    trap_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (irq_req),
        .irq_cause_i (irq_cause),
        .irq_grant_i (irq_grant),
        .glb_ie_i    (glb_ie_i),
        .prev_ie_i   (prev_ie_i),
        .exc_vld_i   (exc_vld_i),
        .exc_code_i  (exc_code_i),
        .pc_i        (pc_i),
        .ret_i       (ret_i),
        .saved_pc_i  (saved_pc_i),
        .out_o       (res)
    );

    assign redir_vld_o = res.redir_vld;
    assign redir_pc_o  = res.redir_pc;
    assign trap_o      = res.trap;
    assign cause_we_o  = res.cause_we;
    assign epc_o       = res.epc;
    assign cause_o     = res.cause;
    assign stat_we_o   = res.stat_we;
    assign glb_ie_o    = res.glb_ie;
    assign prev_ie_o   = res.prev_ie;

    a_r11_redir_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> redir_vld_o);
endmodule

// File: tb/vec_trap_ctrl_tb_top.sv
module vec_trap_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        boundary_i = 0, glb_ie_i = 0, prev_ie_i = 0, exc_vld_i = 0, ret_i = 0;
    logic [31:0] irq_en_i = 0, irq_pend_i = 0, pc_i = 0, saved_pc_i = 0;
    logic [3:0]  exc_code_i = 0;
    logic        redir_vld_o, trap_o, cause_we_o, stat_we_o, glb_ie_o, prev_ie_o;
    logic [31:0] redir_pc_o, epc_o, cause_o;

    vec_trap_ctrl dut_i (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // expectation for the cycle after the current stimulus
    logic [31:0] e_pc, e_epc, e_cause;
    logic        e_vld, e_trap, e_cwe, e_swe, e_ie, e_pie;
    string       e_tag;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic compare();
        logic [134:0] act, exp;
        act = {redir_vld_o, redir_pc_o, trap_o, cause_we_o, epc_o, cause_o, stat_we_o, glb_ie_o, prev_ie_o};
        exp = {e_vld, e_pc, e_trap, e_cwe, e_epc, e_cause, e_swe, e_ie, e_pie};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual vld=%0b pc=%h trap=%0b cwe=%0b epc=%h cause=%h swe=%0b ie=%0b pie=%0b expected vld=%0b pc=%h trap=%0b cwe=%0b epc=%h cause=%h swe=%0b ie=%0b pie=%0b",
                e_tag, redir_vld_o, redir_pc_o, trap_o, cause_we_o, epc_o, cause_o, stat_we_o, glb_ie_o, prev_ie_o,
                e_vld, e_pc, e_trap, e_cwe, e_epc, e_cause, e_swe, e_ie, e_pie);
        end
    endtask

    function automatic bit supported(input logic [3:0] c);
        return c == 0 || c == 1 || c == 2 || c == 3 || c == 5 || c == 7 || c == 11;
    endfunction

    task automatic model();
        int cause;
        cause = -1;
        if (boundary_i && glb_ie_i) begin
            if (irq_en_i[11] && irq_pend_i[11])     cause = 11;
            else if (irq_en_i[3] && irq_pend_i[3])  cause = 3;
            else if (irq_en_i[7] && irq_pend_i[7])  cause = 7;
        end
        {e_vld, e_pc, e_trap, e_cwe, e_epc, e_cause, e_swe, e_ie, e_pie} = '0;
        e_tag = "R12 idle";
        if (cause >= 0) begin
            e_vld = 1; e_trap = 1; e_cwe = 1; e_swe = 1;
            e_pc = 32'h8 + 32'(cause) * 4;
            e_cause = 32'h8000_0000 | 32'(cause);
            e_epc = pc_i; e_ie = 0; e_pie = glb_ie_i;
            e_tag = (exc_vld_i || ret_i) ? "R10 irq over exc/ret" : "R2 R3 R4 R8 irq entry";
        end else if (exc_vld_i) begin
            e_vld = 1; e_trap = 1; e_cwe = 1; e_swe = 1;
            e_pc = 32'h8;
            e_cause = supported(exc_code_i) ? 32'(exc_code_i) : 32'd2;
            e_epc = pc_i; e_ie = 0; e_pie = glb_ie_i;
            e_tag = ret_i ? "R10 exc over ret" : (supported(exc_code_i) ? "R5 R7 exception" : "R6 unsupported code");
        end else if (ret_i) begin
            e_vld = 1; e_swe = 1; e_pc = saved_pc_i;
            e_ie = prev_ie_i; e_pie = 1;
            e_tag = "R9 return";
        end
    endtask

    // compare the previous stimulus's result, then apply a new one
    task automatic step(input logic b, ie, pie, input logic [31:0] en, pnd,
                        input logic ex, input logic [3:0] code, input logic [31:0] pc,
                        input logic rt, input logic [31:0] spc);
        @(negedge clk);
        compare();
        boundary_i = b; glb_ie_i = ie; prev_ie_i = pie; irq_en_i = en; irq_pend_i = pnd;
        exc_vld_i = ex; exc_code_i = code; pc_i = pc; ret_i = rt; saved_pc_i = spc;
        model();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        {e_vld, e_pc, e_trap, e_cwe, e_epc, e_cause, e_swe, e_ie, e_pie} = '0;
        e_tag = "R1 reset";
        // R1: reset state, with busy inputs applied during reset
        boundary_i = 1; glb_ie_i = 1; irq_en_i = '1; irq_pend_i = '1; exc_vld_i = 1;
        repeat (3) begin @(negedge clk); compare(); end
        boundary_i = 0; glb_ie_i = 0; irq_en_i = 0; irq_pend_i = 0; exc_vld_i = 0;
        @(negedge clk); compare();
        rst_n = 1;
        @(negedge clk); compare();  // R1 first cycle after reset
        // R2: mask bits outside 3/7/11 ignored; no boundary; no global enable
        step(1, 1, 0, 32'hFFFF_F777, 32'hFFFF_FFFF, 0, 0, 32'h100, 0, 0);
        step(0, 1, 0, 32'h888, 32'h888, 0, 0, 32'h104, 0, 0);
        step(1, 0, 1, 32'h888, 32'h888, 0, 0, 32'h108, 0, 0);
        step(1, 1, 0, 32'h800, 32'h080, 0, 0, 32'h10C, 0, 0);
        // R3 R4: each source alone and in combination
        step(1, 1, 0, 32'h008, 32'h008, 0, 0, 32'h200, 0, 0);
        step(1, 1, 0, 32'h080, 32'h080, 0, 0, 32'h204, 0, 0);
        step(1, 1, 1, 32'h800, 32'h800, 0, 0, 32'h208, 0, 0);
        step(1, 1, 0, 32'h888, 32'h888, 0, 0, 32'h20C, 0, 0);
        step(1, 1, 0, 32'h088, 32'h088, 0, 0, 32'h210, 0, 0);
        // R5 R6 R7 R8: every exception code
        for (int c = 0; c < 16; c++)
            step(0, c[0], c[1], 0, 0, 1, 4'(c), 32'h300 + 32'(c) * 4, 0, 0);
        // R9: return in both previous-enable states
        step(0, 0, 0, 0, 0, 0, 0, 32'h400, 1, 32'h1234_5678);
        step(0, 0, 1, 0, 0, 0, 0, 32'h404, 1, 32'h2000_0010);
        // R10: all strobes together; exception with return
        step(1, 1, 1, 32'h008, 32'h008, 1, 4'd2, 32'h500, 1, 32'h40);
        step(1, 0, 1, 32'h008, 32'h008, 1, 4'd11, 32'h504, 1, 32'h40);
        // R11: back-to-back results, each present for one cycle only
        step(0, 0, 0, 0, 0, 1, 4'd3, 32'h600, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 32'h604, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 32'h608, 0, 0);
        // R12: wait instruction presented as plain cycle
        step(1, 1, 0, 0, 32'h888, 0, 0, 32'h700, 0, 0);
        // randomized mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] m1, m2;
            m1 = $urandom() & ($urandom_range(0, 1) ? 32'h888 : 32'hFFFF_FFFF);
            m2 = $urandom();
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 m1, m2, ($urandom_range(0, 9) < 3), 4'($urandom()), $urandom(),
                 ($urandom_range(0, 9) < 2), $urandom());
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); compare();
        finish_run();
    end
endmodule